// File: doc/BRIEF.md
# Transmit Buffer Admission Gate

This block decides whether a new read DMA request may be issued into a shared transmit data buffer. Four read DMA channels draw from that buffer. Each channel has a length register holding the byte count of the send buffer whose descriptor was fetched for it. The four lengths are summed and compared with the free space the buffer reports. The request-enable output is high only when the free space is strictly larger than the total.

Length registers could come out of power-up holding garbage. If those values added up to more than the buffer can hold, no request could ever start, and the gate would deadlock. Two measures guard against this. First, the registers are cleared by a reset that is asserted asynchronously and released synchronously, so they leave reset at zero. Second, a bypass select feeds a fixed alternate value (zero by default) to every adder input in place of the stored lengths. With the bypass set, the enable depends only on free space.

A channel's register takes a new value on a one-cycle load strobe, carrying the 16-bit length from the fetched descriptor. The enable is a flop.

Top module: `txbuf_admit_gate`

## Requirements
- R1: While `rst_n` is low, `req_enable` is 0, independent of the clock. Every length register reads zero when reset ends: after reset, with `free_space` = 1 and bypass off, `req_enable` becomes 1.
- R2: A high `load_stb[c]` at a rising edge stores `load_len[16*c+15:16*c]` into channel c's register. Channels whose strobe is low keep their value, whatever `load_len` carries.
- R3: With `bypass_sel` = 0, `req_enable` is 1 exactly when `free_space` > (sum of the four lengths). Equality gives 0.
- R4: The sum is 18 bits wide and cannot wrap. With all four lengths at 0xFFFF the total is 0x3FFFC: `free_space` = 0x3FFFC gives 0 and 0x3FFFD gives 1.
- R5: With `bypass_sel` = 1, each adder input is the alternate value 0. `req_enable` is then 1 exactly when `free_space` > 0, whatever the stored lengths are.
- R6: `req_enable` follows a change of `free_space` or `bypass_sel` at the next rising edge. It follows a load strobe at the second rising edge: one edge to load the register, one to update the enable.
- R7: Reset release is synchronized through two flops. After `rst_n` rises between edges, `req_enable` is still 0 after the first and second rising edges. It can first be 1 after the third.
- R8: Loads are accepted while the bypass is set. Clearing the bypass makes the enable depend again on the lengths stored most recently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; asserted asynchronously, released through a synchronizer |
| load_stb | input | 4 | Per-channel one-cycle load strobe |
| load_len | input | 64 | Per-channel length values; channel c occupies bits 16*c+15 down to 16*c |
| bypass_sel | input | 1 | 0: stored lengths feed the adder; 1: the alternate value feeds it |
| free_space | input | 18 | Free space reported by the transmit data buffer |
| req_enable | output | 1 | High when a new read DMA request may start |

## Verification
A wrong length register shifts the threshold at which `req_enable` toggles. The bench therefore loads length patterns one channel at a time and all at once. For each pattern it sweeps `free_space` across the points just below, at and just above the expected total, so a wrong slice, a lost value or a wrapped sum shows up on the next edge. A wrong reset or synchronizer state appears either as an enable that rises one edge early or late after reset, or as a nonzero threshold right after reset. Bypass faults appear as an enable that still tracks stored lengths while the select is set.

// File: rtl/tbag_pkg.sv
package tbag_pkg;

   // width of a sum of n values of len_w bits, carries included
   function automatic int sum_width(input int len_w, input int n);
      return (n > 1) ? len_w + $clog2(n) : len_w;
   endfunction

   function automatic int max_int(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   function automatic bit is_pow2(input int n);
      return (n > 0) && ((n & (n - 1)) == 0);
   endfunction

endpackage

// File: rtl/tbag_rst_sync.sv
module tbag_rst_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   output logic rst_sync_n
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("tbag_rst_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] shreg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg <= '0;
      end else begin
         shreg <= {shreg[STAGES-2:0], 1'b1};
      end
   end

   assign rst_sync_n = shreg[STAGES-1];

endmodule

// File: rtl/tbag_len_bank.sv
module tbag_len_bank #(
   parameter int NUM_CH = 4,
   parameter int LEN_W  = 16
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [NUM_CH-1:0]       load_stb,
   input  logic [NUM_CH*LEN_W-1:0] load_len,
   output logic [NUM_CH*LEN_W-1:0] len_q
);

   generate
      for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
         logic [LEN_W-1:0] len_r;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               len_r <= '0;
            end else if (load_stb[c]) begin
               len_r <= load_len[c*LEN_W +: LEN_W];
            end
         end

         assign len_q[c*LEN_W +: LEN_W] = len_r;
      end
   endgenerate

endmodule

// File: rtl/tbag_sum.sv
module tbag_sum #(
   parameter int               NUM_CH   = 4,
   parameter int               LEN_W    = 16,
   parameter int               SUM_W    = 18,
   parameter logic [LEN_W-1:0] ALT_LEN  = '0,
   parameter bit               ADD_TREE = 1'b1
) (
   input  logic [NUM_CH*LEN_W-1:0] len_q,
   input  logic                    bypass_sel,
   output logic [SUM_W-1:0]        sum
);

   logic [SUM_W-1:0] opnd [NUM_CH];

   // input multiplexers: stored length or the alternate value
   generate
      for (genvar i = 0; i < NUM_CH; i++) begin : g_mux
         assign opnd[i] = bypass_sel ? SUM_W'(ALT_LEN)
                                     : SUM_W'(len_q[i*LEN_W +: LEN_W]);
      end
   endgenerate

   generate
      if (ADD_TREE) begin : g_tree
         // heap-ordered tree: leaves at NUM_CH..2*NUM_CH-1, root at 1
         logic [SUM_W-1:0] node [1:2*NUM_CH-1];

         for (genvar i = 0; i < NUM_CH; i++) begin : g_leaf
            assign node[NUM_CH+i] = opnd[i];
         end
         for (genvar k = NUM_CH - 1; k >= 1; k--) begin : g_node
            assign node[k] = node[2*k] + node[2*k+1];
         end
         assign sum = node[1];
      end else begin : g_chain
         logic [SUM_W-1:0] part [0:NUM_CH];

         assign part[0] = '0;
         for (genvar i = 0; i < NUM_CH; i++) begin : g_step
            assign part[i+1] = part[i] + opnd[i];
         end
         assign sum = part[NUM_CH];
      end
   endgenerate

endmodule

// File: rtl/txbuf_admit_gate.sv
module txbuf_admit_gate
   import tbag_pkg::*;
#(
   parameter int               NUM_CH     = 4,
   parameter int               LEN_W      = 16,
   parameter int               SPACE_W    = 18,
   parameter logic [LEN_W-1:0] ALT_LEN    = '0,
   parameter int               RST_STAGES = 2,
   parameter bit               ADD_TREE   = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [NUM_CH-1:0]       load_stb,
   input  logic [NUM_CH*LEN_W-1:0] load_len,
   input  logic                    bypass_sel,
   input  logic [SPACE_W-1:0]      free_space,
   output logic                    req_enable
);

   localparam int SUM_W = sum_width(LEN_W, NUM_CH);
   localparam int CMP_W = max_int(SUM_W, SPACE_W);

   generate
      if (NUM_CH < 1) begin : g_bad_ch
         $error("txbuf_admit_gate: NUM_CH must be at least 1");
      end
      if (LEN_W < 1) begin : g_bad_len
         $error("txbuf_admit_gate: LEN_W must be at least 1");
      end
      if (SPACE_W < 1) begin : g_bad_space
         $error("txbuf_admit_gate: SPACE_W must be at least 1");
      end
      if (ADD_TREE && !is_pow2(NUM_CH)) begin : g_bad_tree
         $error("txbuf_admit_gate: adder tree needs a power-of-two NUM_CH");
      end
   endgenerate

   logic                    rst_int_n;
   logic [NUM_CH*LEN_W-1:0] len_q;
   logic [SUM_W-1:0]        sum_w;
   logic                    admit_d;

   tbag_rst_sync #(
      .STAGES (RST_STAGES)
   ) u_rst_sync (
      .clk        (clk),
      .rst_n      (rst_n),
      .rst_sync_n (rst_int_n)
   );

   tbag_len_bank #(
      .NUM_CH (NUM_CH),
      .LEN_W  (LEN_W)
   ) u_len_bank (
      .clk      (clk),
      .rst_n    (rst_int_n),
      .load_stb (load_stb),
      .load_len (load_len),
      .len_q    (len_q)
   );

   tbag_sum #(
      .NUM_CH   (NUM_CH),
      .LEN_W    (LEN_W),
      .SUM_W    (SUM_W),
      .ALT_LEN  (ALT_LEN),
      .ADD_TREE (ADD_TREE)
   ) u_sum (
      .len_q      (len_q),
      .bypass_sel (bypass_sel),
      .sum        (sum_w)
   );

   // strict compare: equal space is not enough
   assign admit_d = CMP_W'(free_space) > CMP_W'(sum_w);

   always_ff @(posedge clk or negedge rst_int_n) begin
      if (!rst_int_n) begin
         req_enable <= 1'b0;
      end else begin
         req_enable <= admit_d;
      end
   end

endmodule

// File: rtl/tbag_chk.sv
module tbag_chk #(
   parameter int               NUM_CH  = 4,
   parameter int               LEN_W   = 16,
   parameter int               SPACE_W = 18,
   parameter int               SUM_W   = 18,
   parameter logic [LEN_W-1:0] ALT_LEN = '0
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    rst_int_n,
   input logic [NUM_CH-1:0]       load_stb,
   input logic [NUM_CH*LEN_W-1:0] load_len,
   input logic [NUM_CH*LEN_W-1:0] len_q,
   input logic [SUM_W-1:0]        sum_w,
   input logic                    bypass_sel,
   input logic [SPACE_W-1:0]      free_space,
   input logic                    req_enable
);

   localparam int CMP_W = (SUM_W > SPACE_W) ? SUM_W : SPACE_W;
   localparam logic [CMP_W-1:0] ALT_TOT = CMP_W'(NUM_CH) * CMP_W'(ALT_LEN);

   logic gt_sum;
   logic gt_alt;
   assign gt_sum = CMP_W'(free_space) > CMP_W'(sum_w);
   assign gt_alt = CMP_W'(free_space) > ALT_TOT;

   AST_RST_QUIET: assert property (@(posedge clk)
      !rst_int_n |-> !req_enable); // R1

   AST_RST_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
      rst_int_n |-> $past(rst_n)); // R7

   AST_CMP_LEN: assert property (@(posedge clk) disable iff (!rst_int_n)
      !bypass_sel |=> (req_enable == $past(gt_sum))); // R3

   AST_CMP_ALT: assert property (@(posedge clk) disable iff (!rst_int_n)
      bypass_sel |=> (req_enable == $past(gt_alt))); // R5

   generate
      for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
         AST_LEN_LOAD: assert property (@(posedge clk) disable iff (!rst_int_n)
            load_stb[c] |=> (len_q[c*LEN_W +: LEN_W] ==
                             $past(load_len[c*LEN_W +: LEN_W]))); // R2

         AST_LEN_HOLD: assert property (@(posedge clk) disable iff (!rst_int_n)
            !load_stb[c] |=> $stable(len_q[c*LEN_W +: LEN_W])); // R2

         AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_int_n)
            !bypass_sel |-> (sum_w >= SUM_W'(len_q[c*LEN_W +: LEN_W]))); // R4
      end
   endgenerate

endmodule

bind txbuf_admit_gate tbag_chk #(
   .NUM_CH  (NUM_CH),
   .LEN_W   (LEN_W),
   .SPACE_W (SPACE_W),
   .SUM_W   (SUM_W),
   .ALT_LEN (ALT_LEN)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .rst_int_n  (rst_int_n),
   .load_stb   (load_stb),
   .load_len   (load_len),
   .len_q      (len_q),
   .sum_w      (sum_w),
   .bypass_sel (bypass_sel),
   .free_space (free_space),
   .req_enable (req_enable)
);

// File: tb/txbuf_admit_gate_bench.sv
`timescale 1ns/1ps
module txbuf_admit_gate_bench;

   localparam int  NUM_CH    = 4;
   localparam int  LEN_W     = 16;
   localparam int  SPACE_W   = 18;
   localparam longint SPACE_MAX = (longint'(1) << SPACE_W) - 1;

   logic                    clk = 1'b0;
   logic                    rst_n;
   logic [NUM_CH-1:0]       load_stb;
   logic [NUM_CH*LEN_W-1:0] load_len;
   logic                    bypass_sel;
   logic [SPACE_W-1:0]      free_space;
   logic                    req_enable;

   int     n_chk = 0;
   int     n_bad = 0;
   bit     done  = 1'b0;
   longint mdl   [NUM_CH];
   longint stage [NUM_CH];

   always #2.5 clk = ~clk;

   txbuf_admit_gate u_txbuf_admit_gate (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_stb   (load_stb),
      .load_len   (load_len),
      .bypass_sel (bypass_sel),
      .free_space (free_space),
      .req_enable (req_enable)
   );

   function automatic longint msum();
      longint s = 0;
      for (int c = 0; c < NUM_CH; c++) s += mdl[c];
      return s;
   endfunction

   function automatic logic exp_en(input longint fs, input logic byp);
      return byp ? (fs > 0) : (fs > msum());
   endfunction

   task automatic chk(input string tag, input logic got, input logic exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: req_enable=%0b expected %0b (free=%0d sum=%0d bypass=%0b)",
                  tag, got, exp, free_space, msum(), bypass_sel);
      end
   endtask

   task automatic report();
      if (!done) begin
         done = 1'b1;
         $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   endtask

   // drive strobes at a falling edge; returns one rising edge later
   task automatic put_load(input logic [NUM_CH-1:0] mask);
      for (int c = 0; c < NUM_CH; c++) begin
         load_len[c*LEN_W +: LEN_W] = LEN_W'(stage[c]);
         if (mask[c]) mdl[c] = stage[c];
      end
      load_stb = mask;
      @(negedge clk);
      load_stb = '0;
      load_len = {NUM_CH{16'hBEEF}};
   endtask

   task automatic set_free(input longint fs);
      free_space = SPACE_W'(fs);
   endtask

   task automatic sweep(input string tag);
      longint s = msum();
      longint pts [7];
      pts = '{0, 1, s - 1, s, s + 1, s + 2, SPACE_MAX};
      for (int i = 0; i < 7; i++) begin
         if (pts[i] >= 0 && pts[i] <= SPACE_MAX) begin
            set_free(pts[i]);
            @(negedge clk);
            chk(tag, req_enable, exp_en(pts[i], bypass_sel));
         end
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not complete");
      report();
   end

   initial begin
      rst_n      = 1'b1;
      load_stb   = '0;
      load_len   = '0;
      bypass_sel = 1'b0;
      free_space = '0;
      for (int c = 0; c < NUM_CH; c++) begin
         mdl[c]   = 0;
         stage[c] = 0;
      end
      #1 rst_n = 1'b0;

      // R1: quiet during reset even with space available
      set_free(100);
      repeat (4) @(negedge clk);
      chk("R1 in reset", req_enable, 1'b0);

      // R7: two-flop synchronized release; R1 lengths cleared
      set_free(1);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R7 edge1", req_enable, 1'b0);
      @(negedge clk);
      chk("R7 edge2", req_enable, 1'b0);
      @(negedge clk);
      chk("R7 edge3 / R1 zero lengths", req_enable, 1'b1);

      // R3: exhaustive free-space sweep on a small total (10)
      stage = '{1, 2, 3, 4};
      put_load('1);
      for (int f = 0; f < 16; f++) begin
         set_free(f);
         @(negedge clk);
         chk("R3 small sweep", req_enable, exp_en(f, 1'b0));
      end

      // R4: widest total must not wrap
      stage = '{65535, 65535, 65535, 65535};
      put_load('1);
      sweep("R4 all max");
      set_free(262140);
      @(negedge clk);
      chk("R4 equal max", req_enable, 1'b0);
      set_free(262141);
      @(negedge clk);
      chk("R4 above max", req_enable, 1'b1);

      // R2: per-channel loads; others keep value, garbage ignored
      for (int p = 0; p < 6; p++) begin
         for (int c = 0; c < NUM_CH; c++) begin
            stage[c] = (p * 4931 + c * 9319 + c * c * p * 7 + 1) % 65536;
            put_load(NUM_CH'(1) << c);
            sweep("R2 single channel");
         end
      end

      // R3: simultaneous loads of several patterns
      for (int p = 0; p < 6; p++) begin
         for (int c = 0; c < NUM_CH; c++)
            stage[c] = (p == 0) ? 0 : (p * 12345 + c * 777 * (p + 1)) % 65536;
         put_load('1);
         sweep("R3 pattern");
      end

      // R6: latency of free space, load and select changes
      stage = '{100, 200, 300, 400};
      put_load('1);
      set_free(1000);
      @(negedge clk);
      chk("R6 at total", req_enable, 1'b0);
      set_free(1001);
      chk("R6 before edge", req_enable, 1'b0);
      @(negedge clk);
      chk("R6 one edge after space", req_enable, 1'b1);
      stage[0] = 101;
      put_load(4'b0001);
      chk("R6 one edge after load", req_enable, 1'b1);
      @(negedge clk);
      chk("R6 two edges after load", req_enable, 1'b0);
      bypass_sel = 1'b1;
      chk("R6 select before edge", req_enable, 1'b0);
      @(negedge clk);
      chk("R6 one edge after select", req_enable, 1'b1);

      // R5: bypass ignores stored lengths
      stage = '{65535, 65535, 65535, 65535};
      put_load('1);
      sweep("R5 bypass");
      set_free(0);
      @(negedge clk);
      chk("R5 bypass zero space", req_enable, 1'b0);

      // R8: loads while bypassed take effect once bypass clears
      stage = '{10, 20, 30, 40};
      put_load('1);
      set_free(50);
      @(negedge clk);
      chk("R8 bypassed", req_enable, 1'b1);
      bypass_sel = 1'b0;
      @(negedge clk);
      chk("R8 restored below", req_enable, 1'b0);
      set_free(101);
      @(negedge clk);
      chk("R8 restored above", req_enable, 1'b1);

      // R1: reset mid-run clears lengths and the enable at once
      stage = '{4000, 4000, 4000, 4000};
      put_load('1);
      rst_n = 1'b0;
      #1;
      chk("R1 async assert", req_enable, 1'b0);
      for (int c = 0; c < NUM_CH; c++) mdl[c] = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      set_free(1);
      repeat (4) @(negedge clk);
      chk("R1 lengths zero after reset", req_enable, 1'b1);

      report();
   end

endmodule